// File: doc/BRIEF.md
# Trap Prioritizer and Entry Sequencer

This block sits beside the execute stage of an integer pipeline. While an instruction runs, any number of sources may raise a trap request in any cycle. Each request carries an 8-bit trap type. The block ranks every request by a fixed urgency table and keeps one pending trap, the most urgent seen since the last instruction boundary. A separate reset request always takes the top slot and supplies its own type code.

When the boundary strobe is high, the block decides whether a trap is taken. Requests that arrive in the boundary cycle itself take part in that decision. If a trap is taken, the block produces the next processor state:
- traps are disabled;
- the mode bits are shifted so the old supervisor bit becomes the previous-supervisor bit, and supervisor mode is entered;
- the window pointer steps down by one, wrapping at the window count;
- the old PC and nPC are presented for storage in the new window;
- the trap type is written into the trap base value, and fetch is redirected there.

If no trap is taken, the block presents the ordinary sequential advance and leaves the state fields unchanged. All state outputs are combinational from the current inputs and the pending entry. The pending entry is cleared at every boundary.

Top module: `trap_sequencer`

## Requirements
- R1: The urgency of a trap type, where a lower number is more urgent, is as follows:

  | Trap type | Urgency |
  |---|---|
  | 0 | 1 |
  | 1 | 2 |
  | 2 | 3 |
  | 3 | 4 |
  | 4 | 5 |
  | 5 and 6 | 6 |
  | 7 | 7 |
  | 8 | 8 |
  | 9 | 10 |
  | 10 | 11 |
  | every other code not covered by R2 | 31 |

- R2: Interrupt types 17 to 31 have urgency 44 minus the type, so type 31 has urgency 13 and type 17 has urgency 27. Every type from 128 to 255 has urgency 12.
- R3: A request arriving after a trap is already pending replaces it only if its urgency number is strictly smaller. On a tie, the earlier pending trap is kept.
- R4: Requests on several ports in the same cycle are resolved to the most urgent one. On equal urgency, the lowest port index wins.
- R5: A reset request always becomes the pending trap, with urgency 1 and type `rst_trap_tt`. It displaces any pending trap, and a later ordinary request does not displace it.
- R6: When a trap is taken, `out_et` is 0, `out_s` is 1, and `out_ps` equals `in_s`.
- R7: When a trap is taken, `out_cwp` equals `in_cwp` minus one, modulo `NWIN`. With the default `NWIN` of 8, 0 becomes 7.
- R8: When a trap is taken, `save_pc` equals `in_pc` and `save_npc` equals `in_npc`. These are the values for the first and second local registers of the new window.
- R9: When a trap is taken, `out_tbr` equals `in_tbr` with bits 11:4 replaced by the trap type, and all other bits kept. `out_pc` equals `out_tbr`, and `out_npc` equals `out_tbr` + 4.
- R10: When no trap is taken, or outside a boundary:
  - `trap_taken` is 0;
  - `out_pc` equals `in_npc` and `out_npc` equals `in_npc` + 4;
  - `out_s`, `out_ps`, `out_et`, `out_cwp` and `out_tbr` equal their inputs.
- R11: The pending trap is cleared at every boundary and by `rst`. The next boundary without new requests takes no trap.
- R12: A trap is taken only in a boundary cycle. Requests in the boundary cycle compete with the pending trap under the rule of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties the pending slot |
| req_vld | input | NREQ | Per-port trap request strobe |
| req_tt | input | NREQ x 8 | Per-port trap type |
| rst_trap_req | input | 1 | Reset trap request, always most urgent |
| rst_trap_tt | input | 8 | Type code reported for the reset request |
| boundary | input | 1 | Instruction boundary strobe |
| in_s | input | 1 | Current supervisor bit |
| in_ps | input | 1 | Current previous-supervisor bit |
| in_et | input | 1 | Current enable-traps bit |
| in_cwp | input | $clog2(NWIN) | Current window pointer |
| in_pc | input | AW | Current PC |
| in_npc | input | AW | Current nPC |
| in_tbr | input | AW | Current trap base value |
| trap_taken | output | 1 | A trap is entered at this boundary |
| out_s | output | 1 | Next supervisor bit |
| out_ps | output | 1 | Next previous-supervisor bit |
| out_et | output | 1 | Next enable-traps bit |
| out_cwp | output | $clog2(NWIN) | Next window pointer |
| save_pc | output | AW | Value for the first saved local register |
| save_npc | output | AW | Value for the second saved local register |
| out_pc | output | AW | Next PC |
| out_npc | output | AW | Next nPC |
| out_tbr | output | AW | Next trap base value |

## Verification
A wrong urgency entry, or a wrong tie rule, shows in `out_tbr` bits 11:4 at the first boundary after the two competing requests. The same-cycle sweep covers every ordered pair of types on two ports. A pending slot that is not cleared shows as a spurious `trap_taken` at the next empty boundary, one instruction later. A pending slot lost by `rst` or by a weaker request shows as a missing or wrong trap at the following boundary. Errors in the entry arithmetic appear combinationally in the same boundary cycle, in the window pointer, the mode bits or the vector pair.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    localparam int TT_W = 8;
    localparam int PR_W = 5;
    localparam logic [PR_W-1:0] PR_RESET = PR_W'(1);

    typedef struct packed {
        logic            vld;
        logic            ovr;
        logic [PR_W-1:0] prio;
        logic [TT_W-1:0] tt;
    } trap_cand_t;

    // Lower number is more urgent.
    function automatic logic [PR_W-1:0] trap_rank(input logic [TT_W-1:0] tt);
        logic [PR_W-1:0] r;
        if (tt[7]) begin
            r = PR_W'(12);
        end else if (tt >= TT_W'(17) && tt <= TT_W'(31)) begin
            r = PR_W'(TT_W'(44) - tt);
        end else begin
            case (tt)
                TT_W'(0):  r = PR_W'(1);
                TT_W'(1):  r = PR_W'(2);
                TT_W'(2):  r = PR_W'(3);
                TT_W'(3):  r = PR_W'(4);
                TT_W'(4):  r = PR_W'(5);
                TT_W'(5),
                TT_W'(6):  r = PR_W'(6);
                TT_W'(7):  r = PR_W'(7);
                TT_W'(8):  r = PR_W'(8);
                TT_W'(9):  r = PR_W'(10);
                TT_W'(10): r = PR_W'(11);
                default:   r = PR_W'(31);
            endcase
        end
        return r;
    endfunction

    function automatic trap_cand_t make_cand(input logic vld, input logic [TT_W-1:0] tt);
        trap_cand_t c;
        c.vld  = vld;
        c.ovr  = 1'b0;
        c.prio = trap_rank(tt);
        c.tt   = tt;
        return c;
    endfunction

    // True when the incoming candidate must displace the incumbent.
    function automatic logic trap_beats(input trap_cand_t inc, input trap_cand_t cur);
        return inc.vld && (inc.ovr || !cur.vld || (inc.prio < cur.prio));
    endfunction

endpackage

// File: rtl/trap_req_merge.sv
module trap_req_merge
    import trap_seq_pkg::*;
#(
    parameter int NREQ = 3
) (
    input  logic [NREQ-1:0]           req_vld,
    input  logic [NREQ-1:0][TT_W-1:0] req_tt,
    input  logic                      rst_trap_req,
    input  logic [TT_W-1:0]           rst_trap_tt,
    output trap_cand_t                cand
);

    trap_cand_t chain [NREQ+1];
    trap_cand_t rst_cand;

    assign chain[0] = '0;

    // Strict comparison along the chain keeps the lower port on ties.
    for (genvar i = 0; i < NREQ; i++) begin : g_fold
        trap_cand_t port_c;
        assign port_c       = make_cand(req_vld[i], req_tt[i]);
        assign chain[i+1]   = trap_beats(port_c, chain[i]) ? port_c : chain[i];
    end

    always_comb begin
        rst_cand.vld  = 1'b1;
        rst_cand.ovr  = 1'b1;
        rst_cand.prio = PR_RESET;
        rst_cand.tt   = rst_trap_tt;
    end

    assign cand = rst_trap_req ? rst_cand : chain[NREQ];

endmodule

// File: rtl/trap_hold.sv
module trap_hold
    import trap_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            boundary,
    input  trap_cand_t      inc,
    output trap_cand_t      pend,
    output logic            win_vld,
    output logic [TT_W-1:0] win_tt
);

    logic take_inc;

    assign take_inc = trap_beats(inc, pend);
    assign win_vld  = take_inc ? inc.vld : pend.vld;
    assign win_tt   = take_inc ? inc.tt  : pend.tt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (boundary) begin
            pend <= '0;
        end else if (take_inc) begin
            pend <= inc;
        end
    end

endmodule

// File: rtl/trap_entry.sv
module trap_entry
    import trap_seq_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int AW   = 32
) (
    input  logic                    boundary,
    input  logic                    win_vld,
    input  logic [TT_W-1:0]         win_tt,
    input  logic                    in_s,
    input  logic                    in_ps,
    input  logic                    in_et,
    input  logic [$clog2(NWIN)-1:0] in_cwp,
    input  logic [AW-1:0]           in_pc,
    input  logic [AW-1:0]           in_npc,
    input  logic [AW-1:0]           in_tbr,
    output logic                    trap_taken,
    output logic                    out_s,
    output logic                    out_ps,
    output logic                    out_et,
    output logic [$clog2(NWIN)-1:0] out_cwp,
    output logic [AW-1:0]           save_pc,
    output logic [AW-1:0]           save_npc,
    output logic [AW-1:0]           out_pc,
    output logic [AW-1:0]           out_npc,
    output logic [AW-1:0]           out_tbr
);

    localparam int CW = $clog2(NWIN);
    localparam logic [AW-1:0] TT_FIELD = AW'({TT_W{1'b1}}) << 4;
    localparam logic [AW-1:0] STEP     = AW'(4);

    logic          take;
    logic [CW-1:0] cwp_dn;
    logic [AW-1:0] vec;

    assign take = boundary && win_vld;

    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2_wrap
        assign cwp_dn = in_cwp - 1'b1;
    end else begin : g_cmp_wrap
        assign cwp_dn = (in_cwp == '0) ? CW'(NWIN - 1) : in_cwp - 1'b1;
    end

    assign vec = (in_tbr & ~TT_FIELD) | (AW'(win_tt) << 4);

    always_comb begin
        trap_taken = take;
        save_pc    = in_pc;
        save_npc   = in_npc;
        if (take) begin
            out_et  = 1'b0;
            out_ps  = in_s;
            out_s   = 1'b1;
            out_cwp = cwp_dn;
            out_tbr = vec;
            out_pc  = vec;
            out_npc = vec + STEP;
        end else begin
            out_et  = in_et;
            out_ps  = in_ps;
            out_s   = in_s;
            out_cwp = in_cwp;
            out_tbr = in_tbr;
            out_pc  = in_npc;
            out_npc = in_npc + STEP;
        end
    end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_seq_pkg::*;
#(
    parameter int NREQ = 3,
    parameter int NWIN = 8,
    parameter int AW   = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NREQ-1:0]           req_vld,
    input  logic [NREQ-1:0][7:0]      req_tt,
    input  logic                      rst_trap_req,
    input  logic [7:0]                rst_trap_tt,
    input  logic                      boundary,
    input  logic                      in_s,
    input  logic                      in_ps,
    input  logic                      in_et,
    input  logic [$clog2(NWIN)-1:0]   in_cwp,
    input  logic [AW-1:0]             in_pc,
    input  logic [AW-1:0]             in_npc,
    input  logic [AW-1:0]             in_tbr,
    output logic                      trap_taken,
    output logic                      out_s,
    output logic                      out_ps,
    output logic                      out_et,
    output logic [$clog2(NWIN)-1:0]   out_cwp,
    output logic [AW-1:0]             save_pc,
    output logic [AW-1:0]             save_npc,
    output logic [AW-1:0]             out_pc,
    output logic [AW-1:0]             out_npc,
    output logic [AW-1:0]             out_tbr
);

    trap_cand_t      inc;
    trap_cand_t      pend;
    logic            win_vld;
    logic [TT_W-1:0] win_tt;

    trap_req_merge #(.NREQ(NREQ)) u_merge (
        .req_vld      (req_vld),
        .req_tt       (req_tt),
        .rst_trap_req (rst_trap_req),
        .rst_trap_tt  (rst_trap_tt),
        .cand         (inc)
    );

    trap_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .inc      (inc),
        .pend     (pend),
        .win_vld  (win_vld),
        .win_tt   (win_tt)
    );

    trap_entry #(.NWIN(NWIN), .AW(AW)) u_entry (
        .boundary   (boundary),
        .win_vld    (win_vld),
        .win_tt     (win_tt),
        .in_s       (in_s),
        .in_ps      (in_ps),
        .in_et      (in_et),
        .in_cwp     (in_cwp),
        .in_pc      (in_pc),
        .in_npc     (in_npc),
        .in_tbr     (in_tbr),
        .trap_taken (trap_taken),
        .out_s      (out_s),
        .out_ps     (out_ps),
        .out_et     (out_et),
        .out_cwp    (out_cwp),
        .save_pc    (save_pc),
        .save_npc   (save_npc),
        .out_pc     (out_pc),
        .out_npc    (out_npc),
        .out_tbr    (out_tbr)
    );

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk
    import trap_seq_pkg::*;
#(
    parameter int NREQ = 3,
    parameter int NWIN = 8,
    parameter int AW   = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NREQ-1:0]         req_vld,
    input logic                    rst_trap_req,
    input logic                    boundary,
    input logic                    in_s,
    input logic [$clog2(NWIN)-1:0] in_cwp,
    input logic [AW-1:0]           in_pc,
    input logic [AW-1:0]           in_npc,
    input logic                    trap_taken,
    input logic                    out_s,
    input logic                    out_ps,
    input logic                    out_et,
    input logic [$clog2(NWIN)-1:0] out_cwp,
    input logic [AW-1:0]           save_pc,
    input logic [AW-1:0]           save_npc,
    input logic [AW-1:0]           out_pc,
    input logic [AW-1:0]           out_npc,
    input logic [AW-1:0]           out_tbr,
    input trap_cand_t              pend
);

    AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (!out_et && out_s && (out_ps == in_s))); // R6

    AST_WINDOW_STEP: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (((int'(out_cwp) + 1) % NWIN) == int'(in_cwp))); // R7

    AST_SAVE_PAIR: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> ((save_pc == in_pc) && (save_npc == in_npc))); // R8

    AST_VECTOR_PAIR: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> ((out_pc == out_tbr) && (out_npc == out_tbr + AW'(4)))); // R9

    AST_PLAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !trap_taken |-> ((out_pc == in_npc) && (out_npc == in_npc + AW'(4)) && (out_cwp == in_cwp))); // R10

    AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> boundary); // R12

    AST_CLEAR_AFTER: assert property (@(posedge clk) disable iff (rst)
        boundary |=> !pend.vld); // R11

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (pend.vld && !boundary && !(|req_vld) && !rst_trap_req) |=> $stable(pend)); // R3

    AST_NO_WORSE: assert property (@(posedge clk) disable iff (rst)
        (pend.vld && !boundary) |=> (pend.vld && (pend.prio <= $past(pend.prio)))); // R3

    AST_RESET_SLOT: assert property (@(posedge clk) disable iff (rst)
        pend.ovr |-> (pend.vld && (pend.prio == PR_RESET))); // R5

endmodule

bind trap_sequencer trap_sequencer_chk #(.NREQ(NREQ), .NWIN(NWIN), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_vld      (req_vld),
    .rst_trap_req (rst_trap_req),
    .boundary     (boundary),
    .in_s         (in_s),
    .in_cwp       (in_cwp),
    .in_pc        (in_pc),
    .in_npc       (in_npc),
    .trap_taken   (trap_taken),
    .out_s        (out_s),
    .out_ps       (out_ps),
    .out_et       (out_et),
    .out_cwp      (out_cwp),
    .save_pc      (save_pc),
    .save_npc     (save_npc),
    .out_pc       (out_pc),
    .out_npc      (out_npc),
    .out_tbr      (out_tbr),
    .pend         (pend)
);

// File: tb/trap_sequencer_bench.sv
module trap_sequencer_bench;

    localparam int CLK_P = 10;
    localparam int NREQ  = 3;
    localparam int NWIN  = 8;
    localparam int AW    = 32;
    localparam int CW    = $clog2(NWIN);

    logic                 clk = 1'b0;
    logic                 rst;
    logic [NREQ-1:0]      req_vld;
    logic [NREQ-1:0][7:0] req_tt;
    logic                 rst_trap_req;
    logic [7:0]           rst_trap_tt;
    logic                 boundary;
    logic                 in_s, in_ps, in_et;
    logic [CW-1:0]        in_cwp;
    logic [AW-1:0]        in_pc, in_npc, in_tbr;
    logic                 trap_taken, out_s, out_ps, out_et;
    logic [CW-1:0]        out_cwp;
    logic [AW-1:0]        save_pc, save_npc, out_pc, out_npc, out_tbr;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    trap_sequencer #(.NREQ(NREQ), .NWIN(NWIN), .AW(AW)) u_trap_sequencer (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_tt(req_tt),
        .rst_trap_req(rst_trap_req), .rst_trap_tt(rst_trap_tt), .boundary(boundary),
        .in_s(in_s), .in_ps(in_ps), .in_et(in_et), .in_cwp(in_cwp),
        .in_pc(in_pc), .in_npc(in_npc), .in_tbr(in_tbr),
        .trap_taken(trap_taken), .out_s(out_s), .out_ps(out_ps), .out_et(out_et),
        .out_cwp(out_cwp), .save_pc(save_pc), .save_npc(save_npc),
        .out_pc(out_pc), .out_npc(out_npc), .out_tbr(out_tbr)
    );

    // Urgency per R1 and R2.
    function automatic int ref_rank(input int t);
        if (t >= 128) return 12;
        if (t >= 17 && t <= 31) return 44 - t;
        if (t <= 4) return t + 1;
        if (t == 5 || t == 6) return 6;
        if (t == 7 || t == 8) return t;
        if (t == 9 || t == 10) return t + 1;
        return 31;
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic quiet();
        req_vld = '0; req_tt = '0; rst_trap_req = 1'b0; rst_trap_tt = '0; boundary = 1'b0;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] exp_vec(input int t);
        return (in_tbr & ~32'h0000_0FF0) | (AW'(t) << 4);
    endfunction

    task automatic expect_trap(input int t, input string rq);
        @(negedge clk);
        chk(trap_taken === 1'b1, rq, trap_taken, 1);
        chk(out_tbr === exp_vec(t), rq, out_tbr, exp_vec(t));
    endtask

    task automatic expect_none(input string rq);
        @(negedge clk);
        chk(trap_taken === 1'b0 && out_pc === in_npc && out_npc === in_npc + 4,
            rq, {trap_taken, out_pc}, {1'b0, in_npc});
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        quiet();
        in_s = 1'b0; in_ps = 1'b1; in_et = 1'b1; in_cwp = CW'(5);
        in_pc = 32'h0000_1000; in_npc = 32'h0000_1004; in_tbr = 32'h1234_5FF7;
        rst = 1'b1;
        next_cycle(); next_cycle();
        rst = 1'b0;

        // Reset state: empty boundary, state passes through (R10, R11)
        boundary = 1'b1;
        @(negedge clk);
        chk(trap_taken === 0 && out_s === in_s && out_ps === in_ps && out_et === in_et
            && out_cwp === in_cwp && out_tbr === in_tbr, "R10 reset state pass-through",
            {trap_taken, out_cwp}, {1'b0, in_cwp});
        chk(out_pc === in_npc && out_npc === in_npc + 4, "R10 sequential advance", out_npc, in_npc + 4);
        next_cycle();
        quiet();

        // Exhaustive same-cycle pairs on ports 0 and 1 at a boundary (R1 R2 R4 R9 R12)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                int w;
                req_vld = 3'b011; req_tt[0] = 8'(a); req_tt[1] = 8'(b); boundary = 1'b1;
                w = (ref_rank(b) < ref_rank(a)) ? b : a;
                @(negedge clk);
                chk(trap_taken === 1'b1 && out_tbr[11:4] === 8'(w), "R4 R1 R2 R12 same-cycle winner",
                    out_tbr[11:4], w);
                chk(out_tbr === exp_vec(w) && out_pc === exp_vec(w) && out_npc === exp_vec(w) + 4,
                    "R9 vector and tbr", out_pc, exp_vec(w));
                next_cycle();
            end
        end
        quiet();

        // Held versus later request (R3 across cycles, R12 with boundary-cycle request)
        for (int v = 0; v < 2; v++) begin
            for (int a = 0; a < 256; a++) begin
                int blist [12] = '{0, 2, 5, 6, 7, 10, 11, 17, 24, 31, 128, 255};
                foreach (blist[k]) begin
                    int b = blist[k];
                    int w = (ref_rank(b) < ref_rank(a)) ? b : a;
                    quiet(); req_vld[1] = 1'b1; req_tt[1] = 8'(a);
                    next_cycle();
                    quiet(); req_vld[0] = 1'b1; req_tt[0] = 8'(b);
                    if (v == 1) boundary = 1'b1;
                    else begin next_cycle(); quiet(); boundary = 1'b1; end
                    @(negedge clk);
                    chk(trap_taken === 1'b1 && out_tbr[11:4] === 8'(w),
                        (v == 1) ? "R12 held vs boundary request" : "R3 strict replace",
                        out_tbr[11:4], w);
                    next_cycle();
                end
            end
        end
        quiet();

        // Clear after boundary (R11)
        req_vld[2] = 1'b1; req_tt[2] = 8'd9; boundary = 1'b1;
        expect_trap(9, "R4 port 2 alone");
        next_cycle(); quiet(); boundary = 1'b1;
        expect_none("R11 cleared after boundary");
        next_cycle(); quiet();

        // rst empties the pending slot (R11)
        req_vld[0] = 1'b1; req_tt[0] = 8'd2;
        next_cycle(); quiet(); rst = 1'b1;
        next_cycle(); rst = 1'b0; boundary = 1'b1;
        expect_none("R11 rst clears pending");
        next_cycle(); quiet();

        // Reset request (R5)
        req_vld[0] = 1'b1; req_tt[0] = 8'd0;
        next_cycle(); quiet(); rst_trap_req = 1'b1; rst_trap_tt = 8'h5A;
        next_cycle(); quiet(); boundary = 1'b1;
        expect_trap(8'h5A, "R5 reset displaces urgency-1 trap");
        next_cycle(); quiet();
        rst_trap_req = 1'b1; rst_trap_tt = 8'h33;
        next_cycle(); quiet(); req_vld[0] = 1'b1; req_tt[0] = 8'd0;
        next_cycle(); quiet(); boundary = 1'b1;
        expect_trap(8'h33, "R5 reset kept against type 0");
        next_cycle(); quiet();
        rst_trap_req = 1'b1; rst_trap_tt = 8'h44; req_vld = 3'b111; req_tt = {8'd0, 8'd1, 8'd0};
        boundary = 1'b1;
        expect_trap(8'h44, "R5 reset in boundary cycle");
        next_cycle(); quiet();

        // Entry state and window wrap over all pointers and mode bits (R6 R7 R8)
        for (int c = 0; c < NWIN; c++) begin
            for (int m = 0; m < 8; m++) begin
                in_cwp = CW'(c); in_s = m[0]; in_ps = m[1]; in_et = m[2];
                in_pc = 32'h0000_2000 + AW'(c * 64 + m * 8); in_npc = in_pc + 4;
                quiet(); req_vld[1] = 1'b1; req_tt[1] = 8'd3; boundary = 1'b1;
                @(negedge clk);
                chk(out_et === 1'b0 && out_s === 1'b1 && out_ps === m[0], "R6 entry mode bits",
                    {out_et, out_s, out_ps}, {2'b01, m[0]});
                chk(out_cwp === CW'((c + NWIN - 1) % NWIN), "R7 window decrement",
                    out_cwp, (c + NWIN - 1) % NWIN);
                chk(save_pc === in_pc && save_npc === in_npc, "R8 saved pc pair", save_pc, in_pc);
                next_cycle();
                quiet(); boundary = 1'b1;
                @(negedge clk);
                chk(trap_taken === 0 && out_cwp === in_cwp && out_s === in_s && out_ps === in_ps
                    && out_et === in_et, "R10 no trap keeps state", {out_cwp, out_s, out_ps, out_et},
                    {in_cwp, in_s, in_ps, in_et});
                next_cycle();
            end
        end
        quiet();

        // Outside a boundary nothing is taken (R12)
        req_vld = 3'b001; req_tt[0] = 8'd1;
        expect_none("R12 no trap without boundary");
        next_cycle(); quiet();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule